// File: doc/BRIEF.md
# CPU Address Window Decoder with Remap

This block sits between a CPU bus and two PCI bus ports. It decides which downstream target a CPU address belongs to. Each PCI port owns five windows: window 0 is an I/O window and windows 1 to 4 are memory windows 0 to 3. Each window has a base register, a size register and a remap register. There is one more window, a movable 64 KiB window that holds the chip's internal register space. A single enable register turns each of these eleven windows on or off, and a window is live only while its enable bit is 0.

The match is purely combinational. The CPU address is compared against every enabled window at the same time, and the lowest-numbered window that matches wins. On a hit the block drives a target code and a translated bus address, computed as the address minus the window start plus the window's remap. A simple register port is used to program the windows: writes take effect at the clock edge, and reads return data combinationally.

A base write also reloads the low half of that window's remap, so that an identity-style mapping follows the base. Software can block this reload with a bit in the configuration register.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset the registers hold these values:
  - enable reads 0x0FBFFF and configuration reads 0;
  - the base of port p window w reads 0x80000 + 0x8000·p + 0x1000·w, and every size reads 0x000F;
  - the internal-space base reads 0x01400.
  With these values only the port 1 I/O window and the internal space are live.
- R2: A base write keeps written bits [25:24] and [19:0] for an I/O window, and bits [26:24] and [19:0] for a memory window. All other bits read back as 0.
- R3: A window starts at base[19:0]·65536 and spans (size+1)·64 KiB. An address hits the window exactly when start ≤ address < start + length.
- R4: The enable register stores 21 bits. Bit 9+5·p+w gates port p window w, bit 20 gates the internal space, and a window can hit only while its bit is 0.
- R5: The remap is 64 bits wide.
  - Writing remap-low loads wdata[15:0] into remap[31:16] and keeps remap[63:32].
  - Writing remap-high loads remap[63:32]; this applies to memory windows only, and an I/O window's remap-high always reads 0.
  - Remap-low reads return remap[31:16], and remap-high reads return remap[63:32].
- R6: A base write also loads wdata[15:0] into remap[31:16], unless configuration bit 27 is 1.
- R7: At reset each window's remap is {base[15:0], 16'h0}, except that memory window 1 of both ports resets to remap 0.
- R8: On a hit, the bus address is address − start + remap, 64 bits wide.
- R9: When several enabled windows match, the one with the lowest target code wins.
- R10: An address that matches no enabled window gives hit 0, target 0 and bus address 0.
- R11: The internal space is a 64 KiB window at internal_base[19:0]·65536. Its remap is 0, so the bus address is the offset into the window.
- R12: Target codes are 1+5·p+w for port windows and 11 for the internal space.
- R13: Register map.
  - When addr[6]=1, addr[1:0] selects a global register: 0 configuration, 1 enable, 2 internal base.
  - When addr[6]=0, addr[5] selects the port, addr[4:2] selects the window (0..4), and addr[1:0] selects base, size, remap-low or remap-high.
  - Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| cpu_addr_i | input | 36 | CPU address to decode |
| hit_o | output | 1 | Address falls in an enabled window |
| target_o | output | 4 | Winning window code, 0 on a miss |
| bus_addr_o | output | 64 | Translated bus address |

## Verification
A corrupted base, size or remap register shows up on the very next decode, because the decode path has no pipeline. The symptom is a hit, target or bus address that is wrong at the edge addresses of the affected window, and the register reads expose the same fault at once. A stale or inverted enable bit shows up as a window that hits when it should miss, or the reverse. A wrong priority order shows up only where windows overlap, so the sweeps deliberately build overlapping windows and internal-space collisions. A mishandled remap reload is visible one cycle after the base write, through a remap-low read and the translated address.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int N_PORT   = 2;
  localparam int N_WIN    = 5;               // per port: 0 = I/O, 1..4 = memory
  localparam int N_SLOT   = N_PORT * N_WIN;
  localparam int AW       = 36;
  localparam int BW       = 20;
  localparam int SW       = 16;
  localparam int RW       = 64;
  localparam int DW       = 32;
  localparam int TW       = 4;
  localparam int RAW      = 7;
  localparam int EN_W     = 21;
  localparam int EN_FIRST = 9;
  localparam int EN_INT   = 20;
  localparam int LOCK_BIT = 27;

  localparam logic [EN_W-1:0] EN_RST   = 21'h0FBFFF;
  localparam logic [BW-1:0]   INT_RST  = 20'h01400;
  localparam logic [SW-1:0]   SIZE_RST = 16'h000F;

  typedef enum logic [1:0] {F_BASE = 2'd0, F_SIZE = 2'd1, F_RLO = 2'd2, F_RHI = 2'd3} win_field_e;
  typedef enum logic [1:0] {G_CFG = 2'd0, G_EN = 2'd1, G_INT = 2'd2, G_NONE = 2'd3} glob_field_e;

  function automatic logic [BW-1:0] rst_base(int p, int w);
    return BW'(32'h80000 + p * 32'h8000 + w * 32'h1000);
  endfunction

  function automatic logic [RW-1:0] rst_remap(int p, int w);
    logic [BW-1:0] b;
    b = rst_base(p, w);
    return (w == 2) ? '0 : {32'h0, b[15:0], 16'h0};
  endfunction
endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs
  import addr_win_pkg::*;
#(
  parameter bit             IS_IO     = 1'b0,
  parameter logic [BW-1:0]  BASE_RST  = '0,
  parameter logic [SW-1:0]  SZ_RST    = '0,
  parameter logic [RW-1:0]  REMAP_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [1:0]    field_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          lock_i,
  output logic [BW-1:0] start_o,
  output logic [SW-1:0] size_o,
  output logic [RW-1:0] remap_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [DW-1:0] KEEP = IS_IO ? 32'h030F_FFFF : 32'h070F_FFFF;

  logic [DW-1:0] base_q;
  logic [SW-1:0] size_q;
  logic [15:0]   rlo_q;
  logic [31:0]   rhi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= {{(DW-BW){1'b0}}, BASE_RST};
      size_q <= SZ_RST;
      rlo_q  <= REMAP_RST[31:16];
      rhi_q  <= REMAP_RST[63:32];
    end else if (sel_i && we_i) begin
      case (field_i)
        F_BASE: begin
          base_q <= wdata_i & KEEP;
          if (!lock_i) rlo_q <= wdata_i[15:0];
        end
        F_SIZE: size_q <= wdata_i[SW-1:0];
        F_RLO:  rlo_q  <= wdata_i[15:0];
        F_RHI:  if (!IS_IO) rhi_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign start_o = base_q[BW-1:0];
  assign size_o  = size_q;
  assign remap_o = {rhi_q, rlo_q, 16'h0};

  always_comb begin
    case (field_i)
      F_BASE:  rdata_o = base_q;
      F_SIZE:  rdata_o = {{(DW-SW){1'b0}}, size_q};
      F_RLO:   rdata_o = {16'h0, rlo_q};
      default: rdata_o = rhi_q;
    endcase
  end
endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
  import addr_win_pkg::*;
(
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] start_i,
  input  logic [SW-1:0] size_i,
  input  logic [RW-1:0] remap_i,
  output logic          hit_o,
  output logic [RW-1:0] xlat_o
);
  localparam int SH = AW - BW;

  logic [AW:0] diff;

  // borrow bit set means address lies below the window start
  assign diff   = {1'b0, addr_i} - {1'b0, start_i, {SH{1'b0}}};
  assign hit_o  = en_i && !diff[AW] && (diff[AW-1:SH] <= {{(BW-SW){1'b0}}, size_i});
  assign xlat_o = {{(RW-AW){1'b0}}, diff[AW-1:0]} + remap_i;
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import addr_win_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  input  logic [AW-1:0]  cpu_addr_i,
  output logic           hit_o,
  output logic [TW-1:0]  target_o,
  output logic [RW-1:0]  bus_addr_o
);
  localparam int N_ALL = N_SLOT + 1;

  logic            glob_sel;
  logic [1:0]      field;
  logic [DW-1:0]   cfg_q;
  logic [EN_W-1:0] en_q;
  logic [BW-1:0]   ib_q;

  logic [N_SLOT-1:0] sel_v;
  logic [BW-1:0]     start_v [N_SLOT];
  logic [SW-1:0]     size_v  [N_SLOT];
  logic [RW-1:0]     remap_v [N_SLOT];
  logic [DW-1:0]     rdata_v [N_SLOT];
  logic [N_ALL-1:0]  hit_v;
  logic [RW-1:0]     xlat_v  [N_ALL];

  assign glob_sel = reg_addr_i[RAW-1];
  assign field    = reg_addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      en_q  <= EN_RST;
      ib_q  <= INT_RST;
    end else if (reg_we_i && glob_sel) begin
      case (field)
        G_CFG: cfg_q <= reg_wdata_i;
        G_EN:  en_q  <= reg_wdata_i[EN_W-1:0];
        G_INT: ib_q  <= reg_wdata_i[BW-1:0];
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    for (genvar w = 0; w < N_WIN; w++) begin : g_win
      localparam int K = p * N_WIN + w;

      assign sel_v[K] = !glob_sel && (reg_addr_i[5] == 1'(p)) && (reg_addr_i[4:2] == 3'(w));

      addr_win_regs #(
        .IS_IO    (w == 0),
        .BASE_RST (rst_base(p, w)),
        .SZ_RST   (SIZE_RST),
        .REMAP_RST(rst_remap(p, w))
      ) i_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (sel_v[K]),
        .we_i   (reg_we_i),
        .field_i(field),
        .wdata_i(reg_wdata_i),
        .lock_i (cfg_q[LOCK_BIT]),
        .start_o(start_v[K]),
        .size_o (size_v[K]),
        .remap_o(remap_v[K]),
        .rdata_o(rdata_v[K])
      );

      addr_win_match i_match (
        .en_i   (!en_q[EN_FIRST + K]),
        .addr_i (cpu_addr_i),
        .start_i(start_v[K]),
        .size_i (size_v[K]),
        .remap_i(remap_v[K]),
        .hit_o  (hit_v[K]),
        .xlat_o (xlat_v[K])
      );
    end
  end

  // internal register space: fixed 64 KiB, no remap
  addr_win_match i_int_match (
    .en_i   (!en_q[EN_INT]),
    .addr_i (cpu_addr_i),
    .start_i(ib_q),
    .size_i ('0),
    .remap_i('0),
    .hit_o  (hit_v[N_SLOT]),
    .xlat_o (xlat_v[N_SLOT])
  );

  // descending scan: the last assignment, the lowest index, wins
  always_comb begin
    hit_o      = 1'b0;
    target_o   = '0;
    bus_addr_o = '0;
    for (int k = N_ALL - 1; k >= 0; k--) begin
      if (hit_v[k]) begin
        hit_o      = 1'b1;
        target_o   = TW'(k + 1);
        bus_addr_o = xlat_v[k];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (glob_sel) begin
      case (field)
        G_CFG:   reg_rdata_o = cfg_q;
        G_EN:    reg_rdata_o = {{(DW-EN_W){1'b0}}, en_q};
        G_INT:   reg_rdata_o = {{(DW-BW){1'b0}}, ib_q};
        default: reg_rdata_o = '0;
      endcase
    end else begin
      for (int k = 0; k < N_SLOT; k++) begin
        if (sel_v[k]) reg_rdata_o = rdata_v[k];
      end
    end
  end
endmodule

// File: rtl/addr_win_decoder_chk.sv
module addr_win_decoder_chk
  import addr_win_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic [RAW-1:0]  reg_addr_i,
  input logic [EN_W-1:0] en_wdata_i,
  input logic [BW-1:0]   cpu_page_i,
  input logic            hit_o,
  input logic [TW-1:0]   target_o,
  input logic [RW-1:0]   bus_addr_o,
  input logic [EN_W-1:0] en_q,
  input logic [BW-1:0]   ib_q
);
  // R10
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (target_o == '0 && bus_addr_o == '0));

  // R12
  target_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (target_o != '0 && target_o <= TW'(N_SLOT + 1)));

  // R4
  enable_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == {1'b1, 4'b0, G_EN}) |=> en_q == $past(en_wdata_i));

  // R4
  int_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q[EN_INT] |-> target_o != TW'(N_SLOT + 1));

  // R11
  int_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && target_o == TW'(N_SLOT + 1)) |-> (cpu_page_i == ib_q && bus_addr_o[RW-1:16] == '0));
endmodule

bind addr_win_decoder addr_win_decoder_chk i_addr_win_decoder_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .en_wdata_i(reg_wdata_i[20:0]),
  .cpu_page_i(cpu_addr_i[35:16]),
  .hit_o     (hit_o),
  .target_o  (target_o),
  .bus_addr_o(bus_addr_o),
  .en_q      (en_q),
  .ib_q      (ib_q)
);

// File: tb/test_addr_win_decoder.sv
module test_addr_win_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [6:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [35:0] cpu_addr_i = '0;
  logic        hit_o;
  logic [3:0]  target_o;
  logic [63:0] bus_addr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] m_base [10];
  logic [15:0] m_size [10];
  logic [15:0] m_rlo  [10];
  logic [31:0] m_rhi  [10];
  logic [31:0] m_cfg;
  logic [20:0] m_en;
  logic [19:0] m_ib;

  always #4 clk_i = ~clk_i;

  addr_win_decoder i_addr_win_decoder (.*);

  function automatic logic [6:0] ra(int p, int w, int f);
    return 7'((p << 5) | (w << 2) | f);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    int k;
    if (a[6]) begin
      case (a[1:0])
        2'd0: m_cfg = d;
        2'd1: m_en = d[20:0];
        2'd2: m_ib = d[19:0];
        default: ;
      endcase
    end else if (a[4:2] < 5) begin
      k = a[5] * 5 + a[4:2];
      case (a[1:0])
        2'd0: begin
          m_base[k] = d & ((a[4:2] == 0) ? 32'h030F_FFFF : 32'h070F_FFFF);
          if (!m_cfg[27]) m_rlo[k] = d[15:0];
        end
        2'd1: m_size[k] = d[15:0];
        2'd2: m_rlo[k] = d[15:0];
        default: if (a[4:2] != 0) m_rhi[k] = d;
      endcase
    end
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  function automatic logic [31:0] exp_rd(logic [6:0] a);
    int k;
    if (a[6]) begin
      case (a[1:0])
        2'd0: return m_cfg;
        2'd1: return {11'h0, m_en};
        2'd2: return {12'h0, m_ib};
        default: return 32'h0;
      endcase
    end
    if (a[4:2] >= 5) return 32'h0;
    k = a[5] * 5 + a[4:2];
    case (a[1:0])
      2'd0: return m_base[k];
      2'd1: return {16'h0, m_size[k]};
      2'd2: return {16'h0, m_rlo[k]};
      default: return (a[4:2] == 0) ? 32'h0 : m_rhi[k];
    endcase
  endfunction

  task automatic rd_chk(logic [6:0] a, string tag);
    reg_addr_i = a;
    #1;
    check(tag, {32'h0, reg_rdata_o}, {32'h0, exp_rd(a)});
  endtask

  task automatic rd_all(string tag);
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < 8; w++)
        for (int f = 0; f < 4; f++) rd_chk(ra(p, w, f), tag);
    for (int f = 0; f < 4; f++) rd_chk(7'h40 | 7'(f), tag);
  endtask

  function automatic logic [63:0] w_start(int k);
    return (k < 10) ? (64'(m_base[k][19:0]) << 16) : (64'(m_ib) << 16);
  endfunction

  function automatic logic [63:0] w_len(int k);
    return (k < 10) ? ((64'(m_size[k]) + 1) << 16) : 64'h10000;
  endfunction

  task automatic ref_dec(logic [35:0] a, output logic h, output logic [3:0] t, output logic [63:0] b);
    logic enb;
    logic [63:0] rm;
    h = 1'b0; t = '0; b = '0;
    for (int k = 0; k < 11; k++) begin
      enb = (k < 10) ? m_en[9 + k] : m_en[20];
      rm  = (k < 10) ? {((k % 5) == 0) ? 32'h0 : m_rhi[k], m_rlo[k], 16'h0} : 64'h0;
      if (!h && !enb && 64'(a) >= w_start(k) && 64'(a) < w_start(k) + w_len(k)) begin
        h = 1'b1;
        t = 4'(k + 1);
        b = 64'(a) - w_start(k) + rm;
      end
    end
  endtask

  task automatic dec_chk(logic [35:0] a, string tag);
    logic h;
    logic [3:0] t;
    logic [63:0] b;
    ref_dec(a, h, t, b);
    cpu_addr_i = a;
    #1;
    check({tag, " hit"}, 64'(hit_o), 64'(h));
    check({tag, " target"}, 64'(target_o), 64'(t));
    check({tag, " bus"}, bus_addr_o, b);
  endtask

  task automatic sweep(string tag);
    logic [63:0] s, l;
    for (int k = 0; k < 11; k++) begin
      s = w_start(k);
      l = w_len(k);
      dec_chk(36'(s - 1), tag);
      dec_chk(36'(s), tag);
      dec_chk(36'(s + (l >> 1) + 64'h123), tag);
      dec_chk(36'(s + l - 1), tag);
      dec_chk(36'(s + l), tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset model (R1, R7)
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < 5; w++) begin
        m_base[p*5+w] = 32'h80000 + 32'(p) * 32'h8000 + 32'(w) * 32'h1000;
        m_size[p*5+w] = 16'h000F;
        m_rlo[p*5+w]  = (w == 2) ? 16'h0 : m_base[p*5+w][15:0];
        m_rhi[p*5+w]  = 32'h0;
      end
    m_cfg = 32'h0;
    m_en  = 21'h0FBFFF;
    m_ib  = 20'h01400;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset enable and register contents; R7: reset remaps
    rd_chk(7'h41, "R1");
    rd_all("R7");
    sweep("R1");

    // R13 R5: program all windows, enable all
    for (int k = 0; k < 10; k++) begin
      wr(ra(k / 5, k % 5, 0), 32'h10000 + 32'(k) * 32'h100);
      wr(ra(k / 5, k % 5, 1), 32'(k));
      wr(ra(k / 5, k % 5, 2), 32'h2000 + 32'(k));
      wr(ra(k / 5, k % 5, 3), 32'h100 * 32'(k) + 32'h7);
    end
    wr(7'h42, 32'h00200);
    wr(7'h41, 32'h0);
    rd_all("R13");
    sweep("R8");

    // R4: each window alone
    for (int k = 0; k < 11; k++) begin
      wr(7'h41, 32'h1F_FFFF & ~(32'h1 << ((k < 10) ? (9 + k) : 20)));
      rd_chk(7'h41, "R4");
      sweep("R4");
    end

    // R9: overlaps, lowest code wins; then disable the winner
    wr(ra(1, 2, 0), 32'h10300);
    wr(ra(1, 2, 1), 32'h20);
    wr(7'h42, 32'h10000);
    wr(7'h41, 32'h0);
    sweep("R9");
    wr(7'h41, 32'h1 << 12 | 32'h1 << 9);
    sweep("R12");

    // R11: internal window alone, moved
    wr(7'h42, 32'h0ABCD);
    wr(7'h41, 32'h0F_FFFF);
    sweep("R11");

    // R6: lock blocks remap reload
    wr(7'h40, 32'h1 << 27);
    wr(ra(0, 4, 0), 32'h0004_5678);
    rd_chk(ra(0, 4, 2), "R6");
    check("R6 lock", {48'h0, m_rlo[4]}, 64'h2004);
    wr(7'h40, 32'h0);
    wr(ra(0, 4, 0), 32'h0004_9ABC);
    rd_chk(ra(0, 4, 2), "R6");
    // R5: low write keeps high half
    wr(ra(0, 4, 2), 32'hFFFF_1357);
    rd_chk(ra(0, 4, 2), "R5");
    rd_chk(ra(0, 4, 3), "R5");
    wr(ra(0, 0, 3), 32'hDEAD_BEEF);
    rd_chk(ra(0, 0, 3), "R5");

    // R2: base masks
    wr(ra(0, 0, 0), 32'hFFFF_FFFF);
    check("R2 io", 64'(exp_rd(ra(0, 0, 0))), 64'h030F_FFFF);
    rd_chk(ra(0, 0, 0), "R2");
    wr(ra(1, 3, 0), 32'hFFFF_FFFF);
    rd_chk(ra(1, 3, 0), "R2");
    // R3: top of address space, full size
    wr(ra(1, 3, 1), 32'hFFFF);
    wr(7'h41, 32'h1F_FFFF & ~(32'h1 << 17) & ~(32'h1 << 9));
    sweep("R3");
    dec_chk(36'hF_FFFF_FFFF, "R3");

    // R10: everything disabled
    wr(7'h41, 32'h1F_FFFF);
    sweep("R10");
    dec_chk(36'h0, "R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule